// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor core that gives every procedure a private window of registers. The windows sit in a ring of physical storage. Each window's outgoing-argument region is the same storage as the incoming-argument region of the window after it, so a caller hands arguments to a callee without copying them. A small group of global registers lies outside the ring and is the same storage from every window. The core addresses registers with a 5-bit virtual number on two combinational read ports and one write port. The block maps that number onto physical storage using the current window.

The block keeps a current-window pointer and a saved-window pointer. A call strobe moves the current window forward around the ring, and a return strobe moves it back. When a call would run into windows that have not yet been saved, the block raises a spill request. When a return would step onto a window that has already been moved out to memory, it raises a fill request. An external handler then moves one window through a dedicated spill/fill port and acknowledges. The block completes the pending call or return in the same clock edge that takes the acknowledge.

Top module: `rwin_file`

## Requirements
- R1: After reset, the current-window pointer and the saved-window pointer are both 0, and neither the spill request nor the fill request is raised.
- R2: Virtual registers 0 to 7 are globals. The same virtual number reaches the same storage whatever the current window.
- R3: A call strobe without a trap moves the current window to the next one, modulo the window count. A return strobe without a trap moves it to the previous one.
- R4: A call whose next window equals the saved-window pointer raises the spill request in the next cycle. The current window stays unchanged, and the spill/fill window output equals the saved-window pointer.
- R5: An acknowledge while the spill request is raised clears it and advances both the saved-window and current-window pointers by one, modulo the window count.
- R6: A return while the current window equals the saved-window pointer raises the fill request in the next cycle. The spill/fill window output equals the saved-window pointer minus one, modulo the window count.
- R7: An acknowledge while the fill request is raised clears it and moves both pointers back by one, modulo the window count.
- R8: Virtual registers 24 to 31 of window w are the same storage as virtual registers 8 to 15 of window w+1.
- R9: Virtual registers 16 to 23 are private to each window. Writing them in one window leaves them unchanged in every other window.
- R10: Virtual register 0 always reads as zero, and writes to it are discarded.
- R11: A read of the register being written in the same cycle returns the value being written.
- R12: Call and return strobes have no effect while a spill or fill request is raised. They also have no effect when both are asserted in the same cycle.
- R13: On the spill/fill port, offsets 0 to 7 address the incoming-argument registers of the trap window and offsets 8 to 15 address its locals. Reads are combinational. Writes take effect only while a request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_vreg | input | 5 | Virtual register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_vreg | input | 5 | Virtual register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_vreg | input | 5 | Virtual register number for the write |
| wr_data | input | 32 | Write data |
| call_stb | input | 1 | Procedure call strobe |
| ret_stb | input | 1 | Procedure return strobe |
| cur_win | output | 3 | Current-window pointer |
| sav_win | output | 3 | Saved-window pointer |
| spill_req | output | 1 | Window overflow: oldest window must be saved |
| fill_req | output | 1 | Window underflow: a window must be restored |
| sf_win | output | 3 | Window addressed by the spill/fill port |
| sf_off | input | 4 | Register offset within the spill/fill window |
| sf_we | input | 1 | Spill/fill write enable |
| sf_wdata | input | 32 | Spill/fill write data |
| sf_rdata | output | 32 | Spill/fill read data |
| sf_ack | input | 1 | Handler acknowledge that completes the trap |

## Verification
On every cycle, the checker verifies pointer motion on calls and returns, when spill and fill requests are raised and how they clear, the pointer updates on acknowledge, that the pointers hold still while a request is outstanding, that the two requests are never raised together, and that register 0 reads zero on both read ports. Only the bench scenarios can show the data side of the mapping. Those scenarios cover arguments written by a caller appearing in the callee, globals seen across windows, locals kept apart, write-to-read forwarding, and data moved through the spill/fill port reappearing at the right virtual registers after the pointers move.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
   // Region selected by the top two bits of a virtual register number
   typedef enum logic [1:0] {
      RG_GLOB = 2'd0,
      RG_PARM = 2'd1,
      RG_LOCL = 2'd2,
      RG_TEMP = 2'd3
   } rgn_e;

   // Number of regions in the virtual register space
   localparam int N_RGN = 4;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
   import rwin_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int RGN  = 8,
   localparam int VW    = $clog2(N_RGN * RGN),
   localparam int OW    = $clog2(RGN),
   localparam int WW    = $clog2(NWIN),
   localparam int WSZ   = 2 * RGN,
   localparam int NPHYS = RGN + NWIN * WSZ,
   localparam int PW    = $clog2(NPHYS)
) (
   input  logic [VW-1:0] vreg,
   input  logic [WW-1:0] win,
   output logic [PW-1:0] phys
);
   rgn_e          rgn;
   logic [OW-1:0] off;
   logic [WW-1:0] win_nx;
   int            base;

   always_comb begin
      rgn    = rgn_e'(vreg[VW-1 -: 2]);
      off    = vreg[OW-1:0];
      win_nx = (win == WW'(NWIN - 1)) ? '0 : win + 1'b1;
      case (rgn)
         RG_GLOB: base = 0;
         RG_PARM: base = RGN + int'(win) * WSZ;
         RG_LOCL: base = RGN + int'(win) * WSZ + RGN;
         default: base = RGN + int'(win_nx) * WSZ;
      endcase
      phys = PW'(base + int'(off));
   end
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
   parameter int NWIN = 8,
   localparam int WW = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_stb,
   input  logic          ret_stb,
   input  logic          ack,
   output logic [WW-1:0] cwp,
   output logic [WW-1:0] swp,
   output logic          ovf_q,
   output logic          unf_q,
   output logic [WW-1:0] twin
);
   function automatic logic [WW-1:0] w_inc(input logic [WW-1:0] v);
      return (v == WW'(NWIN - 1)) ? '0 : v + 1'b1;
   endfunction

   function automatic logic [WW-1:0] w_dec(input logic [WW-1:0] v);
      return (v == '0) ? WW'(NWIN - 1) : v - 1'b1;
   endfunction

   logic do_call, do_ret;

   assign do_call = call_stb && !ret_stb;
   assign do_ret  = ret_stb && !call_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp   <= '0;
         swp   <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else if (ovf_q) begin
         if (ack) begin
            swp   <= w_inc(swp);
            cwp   <= w_inc(cwp);
            ovf_q <= 1'b0;
         end
      end else if (unf_q) begin
         if (ack) begin
            swp   <= w_dec(swp);
            cwp   <= w_dec(cwp);
            unf_q <= 1'b0;
         end
      end else if (do_call) begin
         if (w_inc(cwp) == swp) ovf_q <= 1'b1;
         else                   cwp   <= w_inc(cwp);
      end else if (do_ret) begin
         if (cwp == swp) unf_q <= 1'b1;
         else            cwp   <= w_dec(cwp);
      end
   end

   assign twin = ovf_q ? swp : w_dec(swp);
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
   parameter int DW    = 32,
   parameter int NPHYS = 136,
   parameter int NRD   = 3,
   localparam int PW = $clog2(NPHYS)
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [PW-1:0]           widx,
   input  logic [DW-1:0]           wdat,
   input  logic [NRD-1:0][PW-1:0]  ridx,
   output logic [NRD-1:0][DW-1:0]  rdat
);
   logic [DW-1:0] mem [NPHYS];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdat;
   end

   for (genvar rp = 0; rp < NRD; rp++) begin : g_rd
      always_comb begin
         if (ridx[rp] == '0)                 rdat[rp] = '0;
         else if (we && (widx == ridx[rp]))  rdat[rp] = wdat;
         else                                rdat[rp] = mem[ridx[rp]];
      end
   end
endmodule

// File: rtl/rwin_file.sv
module rwin_file
   import rwin_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int RGN  = 8,
   parameter int DW   = 32,
   localparam int VW = $clog2(N_RGN * RGN),
   localparam int WW = $clog2(NWIN),
   localparam int AW = $clog2(2 * RGN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] rd_a_vreg,
   output logic [DW-1:0] rd_a_data,
   input  logic [VW-1:0] rd_b_vreg,
   output logic [DW-1:0] rd_b_data,
   input  logic          wr_en,
   input  logic [VW-1:0] wr_vreg,
   input  logic [DW-1:0] wr_data,
   input  logic          call_stb,
   input  logic          ret_stb,
   output logic [WW-1:0] cur_win,
   output logic [WW-1:0] sav_win,
   output logic          spill_req,
   output logic          fill_req,
   output logic [WW-1:0] sf_win,
   input  logic [AW-1:0] sf_off,
   input  logic          sf_we,
   input  logic [DW-1:0] sf_wdata,
   output logic [DW-1:0] sf_rdata,
   input  logic          sf_ack
);
   localparam int WSZ   = 2 * RGN;
   localparam int NPHYS = RGN + NWIN * WSZ;
   localparam int PW    = $clog2(NPHYS);
   localparam int NMAP  = 3;   // read A, read B, write
   localparam int NRD   = 3;   // read A, read B, spill/fill

   // Elaboration-time parameter checks
   if (NWIN < 2) begin : g_bad_nwin
      $error("rwin_file: NWIN must be at least 2");
   end
   if ((1 << $clog2(RGN)) != RGN) begin : g_bad_rgn
      $error("rwin_file: RGN must be a power of two");
   end

   logic [NMAP-1:0][VW-1:0] map_v;
   logic [NMAP-1:0][PW-1:0] map_p;
   logic [NRD-1:0][PW-1:0]  rd_idx;
   logic [NRD-1:0][DW-1:0]  rd_dat;
   logic [PW-1:0]           sf_phys;
   logic                    trap;
   logic                    st_we;
   logic [PW-1:0]           st_idx;
   logic [DW-1:0]           st_dat;

   rwin_ptr #(.NWIN(NWIN)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .call_stb (call_stb),
      .ret_stb  (ret_stb),
      .ack      (sf_ack),
      .cwp      (cur_win),
      .swp      (sav_win),
      .ovf_q    (spill_req),
      .unf_q    (fill_req),
      .twin     (sf_win)
   );

   assign map_v[0] = rd_a_vreg;
   assign map_v[1] = rd_b_vreg;
   assign map_v[2] = wr_vreg;

   for (genvar m = 0; m < NMAP; m++) begin : g_map
      rwin_map #(.NWIN(NWIN), .RGN(RGN)) u_map (
         .vreg (map_v[m]),
         .win  (cur_win),
         .phys (map_p[m])
      );
   end

   assign sf_phys = PW'(RGN + int'(sf_win) * WSZ + int'(sf_off));
   assign trap    = spill_req || fill_req;

   // Handler writes win over core writes while a trap is open
   always_comb begin
      if (trap && sf_we) begin
         st_we  = 1'b1;
         st_idx = sf_phys;
         st_dat = sf_wdata;
      end else begin
         st_we  = wr_en && (map_p[2] != '0);
         st_idx = map_p[2];
         st_dat = wr_data;
      end
   end

   assign rd_idx[0] = map_p[0];
   assign rd_idx[1] = map_p[1];
   assign rd_idx[2] = sf_phys;

   rwin_store #(.DW(DW), .NPHYS(NPHYS), .NRD(NRD)) u_store (
      .clk  (clk),
      .we   (st_we),
      .widx (st_idx),
      .wdat (st_dat),
      .ridx (rd_idx),
      .rdat (rd_dat)
   );

   assign rd_a_data = rd_dat[0];
   assign rd_b_data = rd_dat[1];
   assign sf_rdata  = rd_dat[2];
endmodule

// File: rtl/rwin_chk.sv
module rwin_chk #(
   parameter int NWIN = 8,
   parameter int DW   = 32,
   parameter int VW   = 5,
   localparam int WW = $clog2(NWIN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [VW-1:0] rd_a_vreg,
   input logic [DW-1:0] rd_a_data,
   input logic [VW-1:0] rd_b_vreg,
   input logic [DW-1:0] rd_b_data,
   input logic          call_stb,
   input logic          ret_stb,
   input logic [WW-1:0] cur_win,
   input logic [WW-1:0] sav_win,
   input logic          spill_req,
   input logic          fill_req,
   input logic [WW-1:0] sf_win,
   input logic          sf_ack
);
   function automatic logic [WW-1:0] c_inc(input logic [WW-1:0] v);
      return (v == WW'(NWIN - 1)) ? '0 : v + 1'b1;
   endfunction

   function automatic logic [WW-1:0] c_dec(input logic [WW-1:0] v);
      return (v == '0) ? WW'(NWIN - 1) : v - 1'b1;
   endfunction

   logic idle;
   assign idle = !spill_req && !fill_req;

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (cur_win == '0 && sav_win == '0 && !spill_req && !fill_req));

   p_call_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_stb && !ret_stb && c_inc(cur_win) != sav_win)
      |=> cur_win == c_inc($past(cur_win)));

   p_ret_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && ret_stb && !call_stb && cur_win != sav_win)
      |=> cur_win == c_dec($past(cur_win)));

   p_spill_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_stb && !ret_stb && c_inc(cur_win) == sav_win)
      |=> spill_req && $stable(cur_win) && sf_win == sav_win);

   p_spill_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (spill_req && sf_ack)
      |=> !spill_req && sav_win == c_inc($past(sav_win))
          && cur_win == c_inc($past(cur_win)));

   p_fill_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && ret_stb && !call_stb && cur_win == sav_win)
      |=> fill_req && $stable(cur_win) && sf_win == c_dec(sav_win));

   p_fill_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && sf_ack)
      |=> !fill_req && sav_win == c_dec($past(sav_win))
          && cur_win == c_dec($past(cur_win)));

   p_trap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !sf_ack) |=> $stable(cur_win) && $stable(sav_win) && !idle);

   p_both_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_stb && ret_stb) |=> $stable(cur_win) && idle);

   p_one_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({spill_req, fill_req}) <= 1);

   p_zero_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_a_vreg == '0) |-> (rd_a_data == '0))
      and ((rd_b_vreg == '0) |-> (rd_b_data == '0)));
endmodule

bind rwin_file rwin_chk #(.NWIN(NWIN), .DW(DW), .VW(VW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_a_vreg (rd_a_vreg),
   .rd_a_data (rd_a_data),
   .rd_b_vreg (rd_b_vreg),
   .rd_b_data (rd_b_data),
   .call_stb  (call_stb),
   .ret_stb   (ret_stb),
   .cur_win   (cur_win),
   .sav_win   (sav_win),
   .spill_req (spill_req),
   .fill_req  (fill_req),
   .sf_win    (sf_win),
   .sf_ack    (sf_ack)
);

// File: tb/sim_rwin_file.sv
module sim_rwin_file;
   localparam int NWIN = 8;
   localparam int DW   = 32;
   localparam int NVEC = 20;

   // Vector: {op[1:0], cur[2:0], sav[2:0], spill, fill}; op 1=call 2=return 3=ack
   localparam logic [9:0] VEC [NVEC] = '{
      {2'd1, 3'd1, 3'd0, 2'b00}, {2'd1, 3'd2, 3'd0, 2'b00},
      {2'd1, 3'd3, 3'd0, 2'b00}, {2'd1, 3'd4, 3'd0, 2'b00},
      {2'd1, 3'd5, 3'd0, 2'b00}, {2'd1, 3'd6, 3'd0, 2'b00},
      {2'd1, 3'd7, 3'd0, 2'b00}, {2'd1, 3'd7, 3'd0, 2'b10},
      {2'd3, 3'd0, 3'd1, 2'b00}, {2'd2, 3'd7, 3'd1, 2'b00},
      {2'd2, 3'd6, 3'd1, 2'b00}, {2'd2, 3'd5, 3'd1, 2'b00},
      {2'd2, 3'd4, 3'd1, 2'b00}, {2'd2, 3'd3, 3'd1, 2'b00},
      {2'd2, 3'd2, 3'd1, 2'b00}, {2'd2, 3'd1, 3'd1, 2'b00},
      {2'd2, 3'd1, 3'd1, 2'b01}, {2'd3, 3'd0, 3'd0, 2'b00},
      {2'd2, 3'd0, 3'd0, 2'b01}, {2'd3, 3'd7, 3'd7, 2'b00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    rd_a_vreg = '0, rd_b_vreg = '0, wr_vreg = '0;
   logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, sf_wdata = '0, sf_rdata;
   logic          wr_en = 1'b0, call_stb = 1'b0, ret_stb = 1'b0;
   logic [2:0]    cur_win, sav_win, sf_win;
   logic          spill_req, fill_req;
   logic [3:0]    sf_off = '0;
   logic          sf_we = 1'b0, sf_ack = 1'b0;
   int            total = 0;
   int            bad = 0;

   always #10 clk = ~clk;

   rwin_file #(.NWIN(NWIN), .RGN(8), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_a_vreg(rd_a_vreg), .rd_a_data(rd_a_data),
      .rd_b_vreg(rd_b_vreg), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_vreg(wr_vreg), .wr_data(wr_data),
      .call_stb(call_stb), .ret_stb(ret_stb),
      .cur_win(cur_win), .sav_win(sav_win),
      .spill_req(spill_req), .fill_req(fill_req), .sf_win(sf_win),
      .sf_off(sf_off), .sf_we(sf_we), .sf_wdata(sf_wdata),
      .sf_rdata(sf_rdata), .sf_ack(sf_ack)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   // One-cycle strobe; returns at the negedge after the capturing edge
   task automatic step(input logic [1:0] op);
      @(negedge clk);
      call_stb = (op == 2'd1);
      ret_stb  = (op == 2'd2);
      sf_ack   = (op == 2'd3);
      @(negedge clk);
      call_stb = 1'b0; ret_stb = 1'b0; sf_ack = 1'b0;
   endtask

   task automatic wreg(input logic [4:0] v, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_vreg = v; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [4:0] v, input logic [DW-1:0] exp);
      rd_a_vreg = v;
      rd_b_vreg = v;
      #1;
      chk(tag, rd_a_data, exp);
      chk(tag, rd_b_data, exp);
   endtask

   task automatic sfwr(input logic [3:0] off, input logic [DW-1:0] d);
      @(negedge clk);
      sf_we = 1'b1; sf_off = off; sf_wdata = d;
      @(negedge clk);
      sf_we = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 cur", 32'(cur_win), 32'd0);
      chk("R1 sav", 32'(sav_win), 32'd0);
      chk("R1 req", {30'd0, spill_req, fill_req}, 32'd0);

      // Pointer table: R3 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][9:8]);
         chk("R3/R4/R5/R6/R7 cur", 32'(cur_win), 32'(VEC[i][7:5]));
         chk("R3/R4/R5/R6/R7 sav", 32'(sav_win), 32'(VEC[i][4:2]));
         chk("R4/R6 req", {30'd0, spill_req, fill_req}, 32'(VEC[i][1:0]));
      end

      do_reset();
      // R10 register 0
      wreg(5'd0, 32'hFFFF_FFFF);
      rchk("R10", 5'd0, 32'd0);

      wreg(5'd5, 32'h0000_00A5);
      wreg(5'd26, 32'h0000_0026);
      wreg(5'd17, 32'h0000_1700);
      step(2'd1);
      chk("R3 call", 32'(cur_win), 32'd1);
      rchk("R2 global", 5'd5, 32'h0000_00A5);
      rchk("R8 overlap", 5'd10, 32'h0000_0026);
      wreg(5'd17, 32'h0000_1701);
      step(2'd2);
      chk("R3 ret", 32'(cur_win), 32'd0);
      rchk("R9 local", 5'd17, 32'h0000_1700);
      rchk("R2 global back", 5'd5, 32'h0000_00A5);

      // R11 write-to-read forwarding in the same cycle
      @(negedge clk);
      wr_en = 1'b1; wr_vreg = 5'd18; wr_data = 32'h0000_CAFE;
      rd_a_vreg = 5'd18; rd_b_vreg = 5'd18;
      #1;
      chk("R11 a", rd_a_data, 32'h0000_CAFE);
      chk("R11 b", rd_b_data, 32'h0000_CAFE);
      @(negedge clk) wr_en = 1'b0;

      // R12 call and return together
      @(negedge clk);
      call_stb = 1'b1; ret_stb = 1'b1;
      @(negedge clk);
      call_stb = 1'b0; ret_stb = 1'b0;
      chk("R12 both", 32'(cur_win), 32'd0);
      chk("R12 both req", {30'd0, spill_req, fill_req}, 32'd0);

      // R6 fill from depth zero
      step(2'd2);
      chk("R6 req", 32'(fill_req), 32'd1);
      chk("R6 win", 32'(sf_win), 32'd7);
      step(2'd1);
      chk("R12 held cur", 32'(cur_win), 32'd0);
      chk("R12 held req", {30'd0, spill_req, fill_req}, 32'd1);
      sfwr(4'd9, 32'h0000_BEEF);
      sfwr(4'd2, 32'h0000_0077);
      sf_off = 4'd9;
      #1;
      chk("R13 sf read", sf_rdata, 32'h0000_BEEF);
      step(2'd3);
      chk("R7 cur", 32'(cur_win), 32'd7);
      chk("R7 sav", 32'(sav_win), 32'd7);
      rchk("R13 fill local", 5'd17, 32'h0000_BEEF);
      rchk("R13 fill param", 5'd10, 32'h0000_0077);
      sfwr(4'd9, 32'h0000_1234);
      rchk("R13 no trap write", 5'd17, 32'h0000_BEEF);

      // R4 spill of the oldest window
      wreg(5'd20, 32'h0000_4444);
      for (int k = 0; k < 7; k++) step(2'd1);
      chk("R3 wrap", 32'(cur_win), 32'd6);
      step(2'd1);
      chk("R4 req", 32'(spill_req), 32'd1);
      chk("R4 cur", 32'(cur_win), 32'd6);
      chk("R4 win", 32'(sf_win), 32'd7);
      sf_off = 4'd12;
      #1;
      chk("R13 spill read", sf_rdata, 32'h0000_4444);
      step(2'd3);
      chk("R5 cur", 32'(cur_win), 32'd7);
      chk("R5 sav", 32'(sav_win), 32'd0);
      chk("R5 req", 32'(spill_req), 32'd0);

      summary();
   end
endmodule